// File: doc/BRIEF.md
# Multi-Source 16-bit Timer/Counter

This block is a 16-bit up-counter that serves either as an interval timer or as an event counter. A 2-bit source field picks what advances it: an instruction-rate strobe (one clock in four), every system clock, or rising edges on an external count pin. The chosen strobe is ANDed with the run bit and with a gate-enable line from a separate gate unit. It then passes through a prescaler that divides by 1, 2, 4 or 8 before it reaches the count register. When the count wraps from all ones to zero, a sticky overflow flag goes high, and software clears it through the control register.

The external pin is an ordinary sampled input. It can reach the edge detector through a two-flop synchronizer or through a direct path with a single history flop. In external mode the first rising edge after the counter is enabled is not counted unless a falling edge has been seen since then. This stops a pin that is already high at enable from producing a false count.

Software reaches the block through a byte-wide register port. Address 0 is the low count byte, address 1 is the high count byte and address 2 is control. Writes are registered and reads are combinational.

Top module: `evt_timer16`

## Requirements
- R1: With source field 00 the count advances once every 4 system clocks, so exactly 10 times in any 40 consecutive clocks when the prescaler is 1:1. The reserved value 11 behaves identically.
- R2: With source field 01 and a 1:1 prescaler, the count advances on every system clock while running and gated.
- R3: With source field 10 the count advances on rising edges of `ext_in`. With control bit 3 = 1 (direct path), an edge driven before clock edge k is counted at edge k. With bit 3 = 0 (synchronized path), it is counted at edge k+2.
- R4: In external mode a rising edge is counted only if a falling edge has been seen on the selected path since the run bit was last set.
- R5: The prescaler field value p (control bits 2:1) divides the gated strobe by 2^p. A write to either count byte clears the prescaler's partial count.
- R6: The count holds whenever the run bit (control bit 0) is 0 or `gate_en` is 0.
- R7: A wrap from 0xFFFF to 0x0000 sets `ovf_flag`. The flag stays set until a control write carries 0 in bit 6, and an overflow in the same cycle takes priority over that write.
- R8: A write to a count byte is visible on the next clock. It replaces any increment in that cycle and leaves the other byte unchanged.
- R9: The read port returns the low count byte at address 0, the high byte at address 1, and the control byte at address 2. The control byte is laid out as bit 0 run, bits 2:1 prescale, bit 3 direct path, bits 5:4 source, bit 6 flag, bit 7 reading 0. After reset all three read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 low byte, 1 high byte, 2 control) |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Combinational read data |
| ext_in | input | 1 | External count pin |
| gate_en | input | 1 | Count enable from the gate unit |
| ovf_flag | output | 1 | Sticky overflow interrupt flag |

## Verification
Register writes, system-rate and instruction-rate increments, and the overflow flag all appear one clock after the edge that causes them. An external edge shows up after one edge on the direct path and after three edges on the synchronized path. The bench's reference model steps on each rising edge from the inputs held since the previous falling edge. It then compares `rd_data` and `ovf_flag` one nanosecond after that edge, so every comparison falls in the cycle where the result is due. Directed checks read the count across fixed windows of falling edges: 40-cycle deltas for the rates, and single-cycle probes before and after the expected edge for the two external paths.

// File: rtl/evt_timer16_pkg.sv
package evt_timer16_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned PSC_W  = 2;

    typedef enum logic [1:0] {
        SEL_INSTR = 2'b00,
        SEL_SYS   = 2'b01,
        SEL_EXT   = 2'b10,
        SEL_RSVD  = 2'b11
    } clk_sel_e;

    // Control byte bits 5:0, MSB first.
    typedef struct packed {
        clk_sel_e         csel;
        logic             nosync;
        logic [PSC_W-1:0] psc;
        logic             run;
    } ctrl_t;
endpackage

// File: rtl/et_ext_edge.sv
module et_ext_edge #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic nosync,
    input  logic run,
    output logic rise_ok
);
    typedef struct packed {
        logic [SYNC_STAGES:0] sh;
        logic                 raw_prev;
        logic                 armed;
    } edge_st_t;

    edge_st_t st_d, st_q;
    logic rise_sel, fall_sel;

    always_comb begin
        st_d          = st_q;
        st_d.sh       = {st_q.sh[SYNC_STAGES-1:0], ext_in};
        st_d.raw_prev = ext_in;
        if (nosync) begin
            rise_sel = ext_in & ~st_q.raw_prev;
            fall_sel = ~ext_in & st_q.raw_prev;
        end else begin
            rise_sel = st_q.sh[SYNC_STAGES-1] & ~st_q.sh[SYNC_STAGES];
            fall_sel = ~st_q.sh[SYNC_STAGES-1] & st_q.sh[SYNC_STAGES];
        end
        st_d.armed = run & (st_q.armed | fall_sel);
        rise_ok    = rise_sel & st_q.armed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/et_tick_src.sv
module et_tick_src
    import evt_timer16_pkg::*;
#(
    parameter int unsigned PHASE_W = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  clk_sel_e csel,
    input  logic     ext_tick,
    output logic     tick
);
    logic [PHASE_W-1:0] phase_d, phase_q;

    always_comb begin
        phase_d = phase_q + 1'b1;
        unique case (csel)
            SEL_SYS: tick = 1'b1;
            SEL_EXT: tick = ext_tick;
            default: tick = (phase_q == '1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_d;
    end
endmodule

// File: rtl/et_prescale.sv
module et_prescale
    import evt_timer16_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_in,
    input  logic [PSC_W-1:0] ratio,
    input  logic             clear,
    output logic             inc
);
    localparam int unsigned PCNT_W = (1 << PSC_W) - 1;

    logic [PCNT_W-1:0] pcnt_d, pcnt_q, lim;

    always_comb begin
        lim    = PCNT_W'((32'd1 << ratio) - 32'd1);
        inc    = tick_in & ~clear & (pcnt_q >= lim);
        pcnt_d = pcnt_q;
        if (clear)        pcnt_d = '0;
        else if (inc)     pcnt_d = '0;
        else if (tick_in) pcnt_d = pcnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pcnt_q <= '0;
        else        pcnt_q <= pcnt_d;
    end
endmodule

// File: rtl/evt_timer16.sv
module evt_timer16
    import evt_timer16_pkg::*;
#(
    parameter int unsigned CNT_BYTES   = 2,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PHASE_W     = 2,
    parameter int unsigned ADDR_W      = $clog2(CNT_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              ext_in,
    input  logic              gate_en,
    output logic              ovf_flag
);
    localparam int unsigned CNT_W     = CNT_BYTES * BYTE_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CNT_BYTES);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        ctrl_t            ctrl;
        logic             flag;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic ext_tick, src_tick, gated, psc_inc, cnt_wr, wrap;
    logic spare_unused;

    assign spare_unused = wr_data[BYTE_W-1];
    assign cnt_wr       = wr_en && (wr_addr < CTRL_ADDR);
    assign gated        = st_q.ctrl.run & gate_en & src_tick;
    assign ovf_flag     = st_q.flag;

    et_ext_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .ext_in(ext_in),
        .nosync(st_q.ctrl.nosync), .run(st_q.ctrl.run), .rise_ok(ext_tick)
    );

    et_tick_src #(.PHASE_W(PHASE_W)) u_src (
        .clk(clk), .rst_n(rst_n), .csel(st_q.ctrl.csel),
        .ext_tick(ext_tick), .tick(src_tick)
    );

    et_prescale u_psc (
        .clk(clk), .rst_n(rst_n), .tick_in(gated),
        .ratio(st_q.ctrl.psc), .clear(cnt_wr), .inc(psc_inc)
    );

    always_comb begin
        st_d = st_q;
        wrap = 1'b0;
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (wr_en && wr_addr == ADDR_W'(b))
                st_d.cnt[b*BYTE_W +: BYTE_W] = wr_data;
        end
        if (psc_inc)
            {wrap, st_d.cnt} = {1'b0, st_q.cnt} + 1'b1;
        if (wr_en && wr_addr == CTRL_ADDR) begin
            st_d.ctrl = ctrl_t'(wr_data[5:0]);
            st_d.flag = wr_data[6];
        end
        if (wrap) st_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < CNT_BYTES; b++) begin
            if (rd_addr == ADDR_W'(b)) rd_data = st_q.cnt[b*BYTE_W +: BYTE_W];
        end
        if (rd_addr == CTRL_ADDR) rd_data = {1'b0, st_q.flag, st_q.ctrl};
    end
endmodule

// File: rtl/evt_timer16_chk.sv
module evt_timer16_chk #(
    parameter int unsigned CNT_BYTES = 2,
    parameter int unsigned ADDR_W    = 2,
    parameter int unsigned CNT_W     = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              gate_en,
    input logic              run,
    input logic [1:0]        csel,
    input logic [1:0]        psc,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CNT_BYTES);

    // R2
    sys_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && gate_en && csel == 2'b01 && psc == 2'b00 && !wr_en)
        |=> cnt == CNT_W'($past(cnt) + 1'b1));

    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(run && gate_en) && !wr_en) |=> $stable(cnt));

    // R7
    wrap_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '1 && run && gate_en && csel == 2'b01 && psc == 2'b00 && !wr_en)
        |=> (cnt == '0 && flag));

    // R7
    sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(wr_en && wr_addr == CTRL_ADDR)) |=> flag);

    // R8
    lo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> cnt[7:0] == $past(wr_data));

    // R8
    hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == '0) |=> cnt[CNT_W-1:8] == $past(cnt[CNT_W-1:8]));
endmodule

bind evt_timer16 evt_timer16_chk #(
    .CNT_BYTES(CNT_BYTES), .ADDR_W(ADDR_W), .CNT_W(CNT_BYTES * 8)
) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .gate_en(gate_en), .run(st_q.ctrl.run),
    .csel(st_q.ctrl.csel), .psc(st_q.ctrl.psc), .cnt(st_q.cnt),
    .flag(st_q.flag)
);

// File: tb/evt_timer16_tb.sv
`timescale 1ns/1ps
module evt_timer16_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       ext_in = 1'b0;
    logic       gate_en = 1'b1;
    logic       ovf_flag;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    string cur_req = "R9";

    always #2.5 clk = ~clk;

    evt_timer16 u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ext_in(ext_in), .gate_en(gate_en), .ovf_flag(ovf_flag)
    );

    // Behavioural reference model
    int m_cnt, m_pc, m_phase, m_on, m_ps, m_ns, m_cs, m_flag, m_armed;
    int h[4];

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int model_rd(int a);
        case (a)
            0: return m_cnt % 256;
            1: return m_cnt / 256;
            2: return m_on + m_ps * 2 + m_ns * 8 + m_cs * 16 + m_flag * 64;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pc = 0; m_phase = 0; m_on = 0; m_ps = 0;
            m_ns = 0; m_cs = 0; m_flag = 0; m_armed = 0;
            foreach (h[i]) h[i] = 0;
        end else begin
            int rise, fall, src, tick, ovf, nx_armed;
            rise = m_ns ? (ext_in && !h[0]) : (h[1] && !h[2]);
            fall = m_ns ? (!ext_in && h[0]) : (!h[1] && h[2]);
            case (m_cs)
                1: src = 1;
                2: src = rise && m_armed;
                default: src = (m_phase == 3);
            endcase
            nx_armed = m_on ? (m_armed || fall) : 0;
            tick = m_on && gate_en && src;
            ovf = 0;
            if (wr_en && wr_addr < 2) begin
                m_pc = 0;
                if (wr_addr == 0) m_cnt = (m_cnt / 256) * 256 + wr_data;
                else m_cnt = wr_data * 256 + m_cnt % 256;
            end else if (tick) begin
                if (m_pc + 1 >= (1 << m_ps)) begin
                    m_pc = 0;
                    m_cnt++;
                    if (m_cnt == 65536) begin m_cnt = 0; ovf = 1; end
                end else m_pc++;
            end
            if (wr_en && wr_addr == 2) begin
                m_on = wr_data[0]; m_ps = wr_data[2:1]; m_ns = wr_data[3];
                m_cs = wr_data[5:4]; m_flag = wr_data[6];
            end
            if (ovf) m_flag = 1;
            m_armed = nx_armed;
            m_phase = (m_phase + 1) % 4;
            h[3] = h[2]; h[2] = h[1]; h[1] = h[0]; h[0] = ext_in;
            #1;
            check(cur_req, rd_data, model_rd(rd_addr));
            check("R7", ovf_flag, m_flag);
        end
    end

    function automatic logic [7:0] ctl(int run, int ps, int ns, int cs, int fl);
        return 8'(run + ps * 2 + ns * 8 + cs * 16 + fl * 64);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        rd_addr = a;
        #0.5 v = rd_data;
    endtask

    task automatic pulse();
        @(negedge clk); ext_in = 1'b1;
        repeat (4) @(negedge clk);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic window(string req, int cycles, int exp);
        int a, b;
        @(negedge clk); rd(2'd0, a);
        repeat (cycles) @(negedge clk);
        rd(2'd0, b);
        check(req, (b - a) & 255, exp);
    endtask

    initial begin
        int v, a;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state
        for (int i = 0; i < 3; i++) begin rd(2'(i), v); check("R9", v, 0); end

        cur_req = "R2";
        wr(2'd2, ctl(1, 0, 0, 1, 0));
        rd(2'd2, v); check("R9", v, 8'h11);
        window("R2", 40, 40);

        cur_req = "R1";
        wr(2'd2, ctl(1, 0, 0, 0, 0));
        window("R1", 40, 10);
        wr(2'd2, ctl(1, 0, 0, 3, 0));
        window("R1", 40, 10);

        cur_req = "R5";
        for (int p = 1; p < 4; p++) begin
            wr(2'd2, ctl(1, p, 0, 1, 0));
            wr(2'd0, 8'h00);
            rd(2'd0, v); check("R5", v, 0);
            repeat (40) @(negedge clk);
            rd(2'd0, v); check("R5", v, 40 >> p);
        end

        cur_req = "R6";
        wr(2'd2, ctl(1, 0, 0, 1, 0));
        gate_en = 1'b0;
        window("R6", 30, 0);
        gate_en = 1'b1;
        wr(2'd2, ctl(0, 0, 0, 1, 0));
        window("R6", 30, 0);

        cur_req = "R8";
        wr(2'd2, ctl(1, 0, 0, 1, 0));
        rd(2'd1, a);
        wr(2'd0, 8'h80);
        rd(2'd0, v); check("R8", v, 8'h80);
        rd(2'd1, v); check("R8", v, a);

        cur_req = "R7";
        wr(2'd2, ctl(0, 0, 0, 1, 0));
        wr(2'd1, 8'hFF);
        wr(2'd0, 8'hFD);
        wr(2'd2, ctl(1, 0, 0, 1, 0));
        @(negedge clk); @(negedge clk);
        rd(2'd0, v); check("R7", v, 8'hFF);
        check("R7", ovf_flag, 0);
        @(negedge clk);
        rd(2'd1, v); check("R7", v, 8'h00);
        check("R7", ovf_flag, 1);
        wr(2'd2, ctl(0, 0, 0, 1, 1));
        repeat (10) @(negedge clk);
        check("R7", ovf_flag, 1);
        wr(2'd2, ctl(0, 0, 0, 1, 0));
        check("R7", ovf_flag, 0);

        cur_req = "R4";
        wr(2'd0, 8'h00);
        wr(2'd2, ctl(1, 0, 1, 2, 0));
        pulse();
        rd(2'd0, v); check("R4", v, 0);
        pulse(); pulse(); pulse();
        rd(2'd0, v); check("R4", v, 3);

        cur_req = "R3";
        @(negedge clk); rd(2'd0, a); ext_in = 1'b1;
        @(negedge clk); rd(2'd0, v); check("R3", v, a + 1);
        ext_in = 1'b0;
        repeat (4) @(negedge clk);

        wr(2'd2, ctl(0, 0, 0, 2, 0));
        wr(2'd2, ctl(1, 0, 0, 2, 0));
        pulse();
        rd(2'd0, a);
        @(negedge clk); ext_in = 1'b1;
        @(negedge clk); rd(2'd0, v); check("R3", v, a);
        @(negedge clk); rd(2'd0, v); check("R3", v, a);
        @(negedge clk); rd(2'd0, v); check("R3", v, a + 1);
        ext_in = 1'b0;
        repeat (6) @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule